// File: doc/BRIEF.md
# Single-Word SDRAM Access Sequencer

This block turns one-word read and write requests from a simple host bus into SDRAM command sequences. Each accepted request produces an ACTIVE command, a READ or WRITE two clocks later, and a PRECHARGE once the programmed ACTIVE-to-PRECHARGE interval has passed. The block then waits out the precharge recovery before it takes the next request. The linear word address is cut into column, bank and row fields. The row width (11, 12 or 13 bits) and the bank count (2 or 4) come from configuration inputs.

Configuration is shared by all four chip areas. The area select only decides which of the four chip-select lines goes low. Read data is taken with a fixed CAS latency of two clocks and no bursts. If the configuration inputs hold an unsupported latency, burst or row-range code, the block never touches the memory. It answers every request on the next clock with a done pulse that carries an error flag. The cold-reset values of the configuration inputs (latency and burst codes both 11) fall in this case, so the host must program legal codes before the first real access.

Top module: `sdram_word_seq`

## Requirements
- R1: At ACTIVE, `mem_a` carries the row field, zero-extended. The row-range code selects the row width: 00 gives 11 bits, 01 gives 12 bits and 10 gives 13 bits.
- R2: Address split, from bit 0 upward, is an 8-bit column, then the bank field, then the row. With `cfg_four_bank`=1 the bank field is address bits 9:8 and the row starts at bit 10. With `cfg_four_bank`=0 the bank field is bit 8 (`mem_ba[1]`=0) and the row starts at bit 9. `mem_ba` holds the bank in ACTIVE, READ/WRITE and PRECHARGE.
- R3: At READ/WRITE, `mem_a[7:0]` carries the column and all higher address pins are 0, so A10 stays low.
- R4: Commands are encoded on (RAS#, CAS#, WE#) with CS# low as follows: ACTIVE is 011, READ is 101, WRITE is 100, PRECHARGE is 010. READ or WRITE follows ACTIVE exactly 2 clocks later.
- R5: PRECHARGE follows ACTIVE after max(T, 3) clocks. T is the 3-bit timing code, where 1..7 mean 1..7 clocks and 0 means 8 clocks. PRECHARGE never comes earlier than T clocks after ACTIVE.
- R6: The block samples `mem_dq_in` in the clock that starts 2 clocks after READ. That value appears on `rsp_rdata` during the done pulse.
- R7: `mem_dq_oe` is high only in the WRITE command clock, and in that clock `mem_dq_out` equals the request's write data.
- R8: Only `mem_cs_n[req_area]` goes low, and only in command clocks. All other clocks deselect every area.
- R9: If the latency code is not 10, the burst code is not 00, or the row code is 11, a request gives `rsp_done`=`rsp_err`=1 in the next clock. No chip select goes low.
- R10: `rsp_done` is a one-clock pulse max(P, 4)+1 clocks after ACTIVE, where P is the PRECHARGE offset. `busy` is high from ACTIVE until that clock and low during it. Any following ACTIVE comes at least 2 clocks after PRECHARGE.
- R11: In reset and just after it, all chip selects, RAS#, CAS# and WE# are high, and `mem_dq_oe`, `busy` and `rsp_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_row_rng | input | 2 | Row-range code |
| cfg_four_bank | input | 1 | 1: four banks, 0: two banks |
| cfg_ras_code | input | 3 | ACTIVE-to-PRECHARGE code (0 means 8) |
| cfg_cas_code | input | 2 | Latency code, must be 10 |
| cfg_burst_code | input | 2 | Burst code, must be 00 |
| req | input | 1 | Request, taken when `busy` is low |
| req_we | input | 1 | 1: write, 0: read |
| req_addr | input | ADDR_W | Linear word address |
| req_wdata | input | DATA_W | Write data |
| req_area | input | 2 | Chip area select |
| rsp_rdata | output | DATA_W | Read data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_err | output | 1 | Completion refused for bad configuration |
| busy | output | 1 | Sequence in progress |
| mem_cs_n | output | AREAS | Chip selects, active low |
| mem_ras_n | output | 1 | Row strobe |
| mem_cas_n | output | 1 | Column strobe |
| mem_we_n | output | 1 | Write enable |
| mem_a | output | 13 | Address pins |
| mem_ba | output | 2 | Bank address |
| mem_dq_out | output | DATA_W | Data toward memory |
| mem_dq_oe | output | 1 | Data output enable |
| mem_dq_in | input | DATA_W | Data from memory |

## Verification
The hardest case to reach from the ports is the read-capture clock. A capture one clock early or late looks correct if the data pins hold steady. The bench therefore models the memory with a two-stage pipeline triggered by the READ it sees on the pins. It drives the expected word only in the single correct clock and a poison value at all other times. The bench also issues requests back-to-back in the done clock, which exercises the minimum precharge-to-ACTIVE spacing across every timing code.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  localparam int unsigned PIN_A_W = 13;
  localparam int unsigned PIN_BA_W = 2;
  localparam int unsigned RCD_CLK = 2;
  localparam int unsigned CAP_CLK = RCD_CLK + 2;

  typedef enum logic [2:0] {CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE} cmd_e;
  typedef enum logic [0:0] {ST_IDLE, ST_RUN} st_e;

  // {ras_n, cas_n, we_n}
  function automatic logic [2:0] cmd_pins(input cmd_e c);
    case (c)
      CMD_ACT: return 3'b011;
      CMD_RD:  return 3'b101;
      CMD_WR:  return 3'b100;
      CMD_PRE: return 3'b010;
      default: return 3'b111;
    endcase
  endfunction
endpackage

// File: rtl/sdram_cfg_check.sv
module sdram_cfg_check
  import sdram_seq_pkg::*;
(
  input  logic [1:0] row_rng,
  input  logic [2:0] ras_code,
  input  logic [1:0] cas_code,
  input  logic [1:0] burst_code,
  output logic       cfg_bad,
  output logic [3:0] pre_off,
  output logic [3:0] done_off
);
  logic [3:0] tras;
  logic [3:0] last_use;

  always_comb begin
    cfg_bad  = (cas_code != 2'b10) || (burst_code != 2'b00) || (row_rng == 2'b11);
    tras     = (ras_code == 3'd0) ? 4'd8 : {1'b0, ras_code};
    pre_off  = (tras < 4'(RCD_CLK + 1)) ? 4'(RCD_CLK + 1) : tras;
    last_use = (pre_off < 4'(CAP_CLK)) ? 4'(CAP_CLK) : pre_off;
    done_off = last_use + 4'd1;
  end
endmodule

// File: rtl/sdram_addr_split.sv
module sdram_addr_split
  import sdram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned COL_W  = 8
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [1:0]          row_rng,
  input  logic                four_bank,
  output logic [PIN_A_W-1:0]  row,
  output logic [PIN_BA_W-1:0] bank,
  output logic [COL_W-1:0]    col
);
  localparam int unsigned ROW_LO_2B = COL_W + 1;
  localparam int unsigned ROW_LO_4B = COL_W + 2;

  logic [ADDR_W-1:0]  shifted;
  logic [PIN_A_W-1:0] mask;

  always_comb begin
    col     = addr[COL_W-1:0];
    bank    = four_bank ? addr[COL_W+1:COL_W] : {1'b0, addr[COL_W]};
    shifted = four_bank ? (addr >> ROW_LO_4B) : (addr >> ROW_LO_2B);
    case (row_rng)
      2'b00:   mask = 13'h07FF;
      2'b01:   mask = 13'h0FFF;
      default: mask = 13'h1FFF;
    endcase
    row = shifted[PIN_A_W-1:0] & mask;
  end
endmodule

// File: rtl/sdram_word_seq.sv
module sdram_word_seq
  import sdram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned AREAS  = 4,
  parameter int unsigned COL_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 cfg_row_rng,
  input  logic                       cfg_four_bank,
  input  logic [2:0]                 cfg_ras_code,
  input  logic [1:0]                 cfg_cas_code,
  input  logic [1:0]                 cfg_burst_code,
  input  logic                       req,
  input  logic                       req_we,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  input  logic [$clog2(AREAS)-1:0]   req_area,
  output logic [DATA_W-1:0]          rsp_rdata,
  output logic                       rsp_done,
  output logic                       rsp_err,
  output logic                       busy,
  output logic [AREAS-1:0]           mem_cs_n,
  output logic                       mem_ras_n,
  output logic                       mem_cas_n,
  output logic                       mem_we_n,
  output logic [PIN_A_W-1:0]         mem_a,
  output logic [PIN_BA_W-1:0]        mem_ba,
  output logic [DATA_W-1:0]          mem_dq_out,
  output logic                       mem_dq_oe,
  input  logic [DATA_W-1:0]          mem_dq_in
);
  localparam int unsigned AREA_W = $clog2(AREAS);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic               cfg_bad;
  logic [3:0]         pre_off, done_off;
  logic [PIN_A_W-1:0] sp_row;
  logic [PIN_BA_W-1:0] sp_bank;
  logic [COL_W-1:0]   sp_col;

  sdram_cfg_check u_cfg (
    .row_rng(cfg_row_rng), .ras_code(cfg_ras_code), .cas_code(cfg_cas_code),
    .burst_code(cfg_burst_code), .cfg_bad(cfg_bad), .pre_off(pre_off), .done_off(done_off)
  );

  sdram_addr_split #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_split (
    .addr(req_addr), .row_rng(cfg_row_rng), .four_bank(cfg_four_bank),
    .row(sp_row), .bank(sp_bank), .col(sp_col)
  );

  // sequence state
  st_e                 st_q, st_d;
  logic [3:0]          cnt_q, cnt_d, cnt_inc;
  logic                we_q, we_d;
  logic [AREA_W-1:0]   area_q, area_d, area_sel;
  logic [PIN_BA_W-1:0] bank_q, bank_d;
  logic [COL_W-1:0]    col_q, col_d;
  logic [3:0]          pre_q, pre_d, dn_q, dn_d;
  logic                req_en;
  // pin registers
  cmd_e                cmd_q, cmd_d;
  logic [PIN_A_W-1:0]  a_q, a_d;
  logic [PIN_BA_W-1:0] ba_q, ba_d;
  logic [AREAS-1:0]    cs_q, cs_d;
  logic                oe_q, oe_d;
  logic [DATA_W-1:0]   wd_q;
  logic [DATA_W-1:0]   rd_q;
  logic                cap_en;
  logic                done_q, done_d, err_q, err_d;

  always_comb begin
    st_d    = st_q;
    cnt_inc = cnt_q + 4'd1;
    cnt_d   = cnt_q;
    we_d    = we_q;
    area_d  = area_q;
    bank_d  = bank_q;
    col_d   = col_q;
    pre_d   = pre_q;
    dn_d    = dn_q;
    req_en  = 1'b0;
    cmd_d   = CMD_NOP;
    a_d     = '0;
    ba_d    = '0;
    oe_d    = 1'b0;
    cap_en  = 1'b0;
    done_d  = 1'b0;
    err_d   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req && cfg_bad) begin
          done_d = 1'b1;
          err_d  = 1'b1;
        end else if (req) begin
          req_en = 1'b1;
          st_d   = ST_RUN;
          cnt_d  = 4'd0;
          we_d   = req_we;
          area_d = req_area;
          bank_d = sp_bank;
          col_d  = sp_col;
          pre_d  = pre_off;
          dn_d   = done_off;
          cmd_d  = CMD_ACT;
          a_d    = sp_row;
          ba_d   = sp_bank;
        end
      end
      default: begin
        cnt_d = cnt_inc;
        if (cnt_inc == 4'(RCD_CLK)) begin
          cmd_d            = we_q ? CMD_WR : CMD_RD;
          a_d[COL_W-1:0]   = col_q;
          ba_d             = bank_q;
          oe_d             = we_q;
        end else if (cnt_inc == pre_q) begin
          cmd_d = CMD_PRE;
          ba_d  = bank_q;
        end
        cap_en = (cnt_q == 4'(CAP_CLK)) && !we_q;
        if (cnt_inc == dn_q) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
    endcase
    area_sel = (st_q == ST_IDLE) ? req_area : area_q;
    for (int i = 0; i < AREAS; i++)
      cs_d[i] = !((cmd_d != CMD_NOP) && (area_sel == AREA_W'(i)));
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      we_q   <= 1'b0;
      area_q <= '0;
      bank_q <= '0;
      col_q  <= '0;
      pre_q  <= '0;
      dn_q   <= '0;
      cmd_q  <= CMD_NOP;
      a_q    <= '0;
      ba_q   <= '0;
      cs_q   <= '1;
      oe_q   <= 1'b0;
      wd_q   <= '0;
      rd_q   <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      we_q   <= we_d;
      area_q <= area_d;
      bank_q <= bank_d;
      col_q  <= col_d;
      pre_q  <= pre_d;
      dn_q   <= dn_d;
      cmd_q  <= cmd_d;
      a_q    <= a_d;
      ba_q   <= ba_d;
      cs_q   <= cs_d;
      oe_q   <= oe_d;
      done_q <= done_d;
      err_q  <= err_d;
      if (req_en) wd_q <= req_wdata;
      if (cap_en) rd_q <= mem_dq_in;
    end
  end

  assign {mem_ras_n, mem_cas_n, mem_we_n} = cmd_pins(cmd_q);
  assign mem_cs_n   = cs_q;
  assign mem_a      = a_q;
  assign mem_ba     = ba_q;
  assign mem_dq_oe  = oe_q;
  assign mem_dq_out = wd_q;
  assign rsp_rdata  = rd_q;
  assign rsp_done   = done_q;
  assign rsp_err    = err_q;
  assign busy       = (st_q != ST_IDLE);
endmodule

// File: rtl/sdram_word_seq_chk.sv
module sdram_word_seq_chk #(
  parameter int unsigned AREAS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AREAS-1:0] mem_cs_n,
  input logic             mem_ras_n,
  input logic             mem_cas_n,
  input logic             mem_we_n,
  input logic             mem_dq_oe,
  input logic             rsp_done,
  input logic             rsp_err,
  input logic             busy,
  input logic [2:0]       cfg_ras_code
);
  logic sel, is_act, is_rw, is_wr, is_pre;
  logic [3:0] since_act, tras_l;

  assign sel    = ~&mem_cs_n;
  assign is_act = sel && !mem_ras_n && mem_cas_n && mem_we_n;
  assign is_rw  = sel && mem_ras_n && !mem_cas_n;
  assign is_wr  = is_rw && !mem_we_n;
  assign is_pre = sel && !mem_ras_n && mem_cas_n && !mem_we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= 4'hF;
      tras_l    <= 4'd0;
    end else if (is_act) begin
      since_act <= 4'd1;
      tras_l    <= (cfg_ras_code == 3'd0) ? 4'd8 : {1'b0, cfg_ras_code};
    end else if (since_act != 4'hF) begin
      since_act <= since_act + 4'd1;
    end
  end

  assert_cs_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));
  assert_rcd_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    is_rw |-> $past(is_act, 2));
  assert_tras_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> (since_act >= tras_l));
  assert_dq_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> is_wr);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !busy);
  assert_trp_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> !$past(is_pre));
  assert_err_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_done && !sel));
endmodule

bind sdram_word_seq sdram_word_seq_chk #(.AREAS(AREAS)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n),
  .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe),
  .rsp_done(rsp_done), .rsp_err(rsp_err), .busy(busy), .cfg_ras_code(cfg_ras_code)
);

// File: tb/sdram_word_seq_tb.sv
module sdram_word_seq_tb;
  localparam int CLK_P = 10;
  localparam int NV = 8;
  // {we, row_rng, four_bank, ras_code, area, addr[23:0], data[15:0]}
  localparam logic [48:0] VECS [NV] = '{
    {1'b0, 2'd0, 1'b0, 3'd1, 2'd0, 24'h012345, 16'h1111},
    {1'b1, 2'd0, 1'b0, 3'd3, 2'd1, 24'hFFFFFF, 16'h2222},
    {1'b0, 2'd1, 1'b1, 3'd0, 2'd2, 24'hABCDEF, 16'h3333},
    {1'b1, 2'd1, 1'b1, 3'd5, 2'd3, 24'h3F0F0F, 16'h4444},
    {1'b0, 2'd2, 1'b1, 3'd7, 2'd1, 24'h7FFF00, 16'h5555},
    {1'b1, 2'd2, 1'b0, 3'd2, 2'd2, 24'h5A5A5A, 16'h6666},
    {1'b0, 2'd2, 1'b0, 3'd4, 2'd3, 24'hC00301, 16'h7777},
    {1'b1, 2'd0, 1'b1, 3'd6, 2'd0, 24'h000000, 16'h8888}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] cfg_row_rng, cfg_cas_code, cfg_burst_code, req_area;
  logic cfg_four_bank, req, req_we;
  logic [2:0] cfg_ras_code;
  logic [23:0] req_addr;
  logic [15:0] req_wdata, rsp_rdata, mem_dq_out, mem_dq_in;
  logic rsp_done, rsp_err, busy, mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe;
  logic [3:0] mem_cs_n;
  logic [12:0] mem_a;
  logic [1:0] mem_ba;

  int checks = 0;
  int bad = 0;
  int cyc = 0;
  int last_pre = -100;
  logic [1:0] rd_pipe;
  logic [15:0] cur_data;

  always #(CLK_P/2) clk = ~clk;

  sdram_word_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_row_rng(cfg_row_rng), .cfg_four_bank(cfg_four_bank),
    .cfg_ras_code(cfg_ras_code), .cfg_cas_code(cfg_cas_code), .cfg_burst_code(cfg_burst_code),
    .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_area(req_area),
    .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .rsp_err(rsp_err), .busy(busy),
    .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_a(mem_a), .mem_ba(mem_ba), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // memory model: word valid only in the clock two after READ
  always @(posedge clk) begin
    cyc <= cyc + 1;
    rd_pipe <= {rd_pipe[0], (mem_cs_n != 4'hF) && mem_ras_n && !mem_cas_n && mem_we_n};
  end
  assign mem_dq_in = rd_pipe[1] ? cur_data : 16'hDEAD;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int pin_cmd();
    if (mem_cs_n == 4'hF) return 0;
    case ({mem_ras_n, mem_cas_n, mem_we_n})
      3'b011: return 1;
      3'b101: return 2;
      3'b100: return 3;
      3'b010: return 4;
      default: return 0;
    endcase
  endfunction

  // called on a falling edge; returns on the falling edge of the done clock
  task automatic run_txn(input logic [48:0] v);
    logic we; logic [1:0] rng, area; logic four; logic [2:0] ras;
    logic [23:0] addr; logic [15:0] data;
    logic [12:0] erow; logic [1:0] ebank; int tras, epre, edone;
    int t_rw, t_pre, t_done, oe_cnt, oe_t;
    logic busy_mid, dq_ok;
    {we, rng, four, ras, area, addr, data} = v;
    erow  = 13'((four ? (addr >> 10) : (addr >> 9)) & ((24'd1 << (11 + rng)) - 1));
    ebank = four ? addr[9:8] : {1'b0, addr[8]};
    tras  = (ras == 0) ? 8 : ras;
    epre  = (tras < 3) ? 3 : tras;
    edone = ((epre < 4) ? 4 : epre) + 1;
    cfg_row_rng = rng; cfg_four_bank = four; cfg_ras_code = ras;
    cfg_cas_code = 2'b10; cfg_burst_code = 2'b00;
    req = 1'b1; req_we = we; req_addr = addr; req_wdata = data; req_area = area;
    cur_data = data;
    @(negedge clk);
    req = 1'b0;
    // t = 0 : ACTIVE
    chk(pin_cmd() == 1 && (cyc - last_pre) >= 2, "R10 act/trp", pin_cmd(), 1);
    chk(mem_a == erow, "R1 row on pins", mem_a, erow);
    chk(mem_ba == ebank, "R2 bank at act", mem_ba, ebank);
    chk(mem_cs_n == ~(4'b1 << area), "R8 area select", mem_cs_n, ~(4'b1 << area));
    t_rw = -1; t_pre = -1; t_done = -1; oe_cnt = 0; oe_t = -1; busy_mid = 1'b0; dq_ok = 1'b1;
    for (int t = 1; t < 16; t++) begin
      @(negedge clk);
      if (t == 1) busy_mid = busy;
      if (mem_dq_oe) begin oe_cnt++; oe_t = t; dq_ok = (mem_dq_out == data); end
      if (pin_cmd() == 1) chk(1'b0, "R8 stray act", t, 0);
      if (pin_cmd() == 2 || pin_cmd() == 3) begin
        t_rw = t;
        chk(pin_cmd() == (we ? 3 : 2) && mem_ba == ebank, "R4 rw type", pin_cmd(), we ? 3 : 2);
        chk(mem_a == 13'(addr[7:0]), "R3 column", mem_a, addr[7:0]);
      end
      if (pin_cmd() == 4) begin
        t_pre = t; last_pre = cyc;
        chk(mem_ba == ebank, "R2 bank at pre", mem_ba, ebank);
      end
      if (rsp_done) begin t_done = t; break; end
    end
    chk(t_rw == 2, "R4 rcd", t_rw, 2);
    chk(t_pre == epre, "R5 precharge offset", t_pre, epre);
    chk(t_done == edone && !busy && busy_mid && !rsp_err, "R10 done timing", t_done, edone);
    if (we) chk(oe_cnt == 1 && oe_t == 2 && dq_ok, "R7 write drive", oe_t, 2);
    else begin
      chk(oe_cnt == 0, "R7 no drive on read", oe_cnt, 0);
      chk(rsp_rdata == data, "R6 read capture", rsp_rdata, data);
    end
  endtask

  task automatic err_case(input logic [1:0] cas, input logic [1:0] bst, input logic [1:0] rng);
    cfg_cas_code = cas; cfg_burst_code = bst; cfg_row_rng = rng;
    req = 1'b1; req_we = 1'b1; req_area = 2'd1; req_addr = 24'h00ABCD;
    @(negedge clk);
    req = 1'b0;
    chk(rsp_done && rsp_err && mem_cs_n == 4'hF && !busy, "R9 refused", {rsp_done, rsp_err}, 3);
    @(negedge clk);
    chk(!rsp_done && mem_cs_n == 4'hF && !mem_dq_oe, "R9 no command", mem_cs_n, 4'hF);
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++;
    $display("FAIL R10 watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0; req_area = '0;
    cfg_row_rng = 2'b00; cfg_four_bank = 1'b0; cfg_ras_code = 3'b000;
    cfg_cas_code = 2'b11; cfg_burst_code = 2'b11; cur_data = '0; rd_pipe = '0;
    repeat (3) @(negedge clk);
    chk(mem_cs_n == 4'hF && {mem_ras_n, mem_cas_n, mem_we_n} == 3'b111 && !mem_dq_oe && !busy
        && !rsp_done, "R11 reset state", {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}, 7'h7F);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(mem_cs_n == 4'hF && !busy && !rsp_done, "R11 after release", mem_cs_n, 4'hF);
    // cold-reset codes are illegal until rewritten
    err_case(2'b11, 2'b11, 2'b00);
    err_case(2'b10, 2'b01, 2'b00);
    err_case(2'b10, 2'b00, 2'b11);
    err_case(2'b01, 2'b00, 2'b01);
    // table walk, back-to-back in the done clock
    for (int i = 0; i < NV; i++) run_txn(VECS[i]);
    // corner: legal config after errors, shortest code then longest
    run_txn({1'b0, 2'd2, 1'b1, 3'd1, 2'd3, 24'hFFFFFF, 16'hBEEF});
    run_txn({1'b1, 2'd0, 1'b0, 3'd0, 2'd0, 24'h0001FF, 16'hCAFE});
    @(negedge clk);
    chk(!rsp_done && !busy, "R10 single pulse", rsp_done, 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule